// File: doc/BRIEF.md
# Halt and Interrupt-Wake Controller

This block sits beside a small 8-bit processor core and owns everything about the core's low-power halt state and its interrupt acceptance. It holds the five-source interrupt request and enable registers, which software reaches through the memory bus. It also holds the master interrupt enable, which the core sets and clears with one-cycle pulses.

When the core reports that it executed the halt opcode, the block classifies the situation. In one class it holds the core stalled. In another it raises a one-cycle flag asking the core to skip its next program-counter increment. The stall ends as soon as any enabled source is pending, even when the master enable is off. Dispatch is a separate decision. Whenever the master enable is on and an enabled source is pending, the block strobes dispatch, presents the vector of the winning source and a one-hot mask of the bit being serviced. At the end of that cycle it drops the master enable and that request bit.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset the master enable is 0, no halt is recorded (mode 0), the request register reads 0xE0, the enable register reads 0x00 and no dispatch is strobed.
- R2: The request register sits at bus address 0xFF0F and reads back with bits 7..5 as 1 and bits 4..0 as stored. The enable register sits at 0xFFFF and reads back the full written byte. Any other address reads 0x00 with the hit flag low. A write takes effect at the next clock edge.
- R3: In a cycle where the request register is written and peripheral set pulses arrive, the new value is the written bits ORed with the pulses. A pulsed bit ends up set even if the write clears it.
- R4: A halt pulse while running, with the master enable set and no dispatch pending, records mode 1 at the next edge and stalls the core.
- R5: A halt pulse while running, with the master enable clear and no enabled request pending, records mode 2 at the next edge and stalls the core.
- R6: A halt pulse while running, with the master enable clear and an enabled request pending, records mode 3 for exactly one cycle. During that cycle the halt-bug flag is high and there is no stall. The block then returns to mode 0.
- R7: While stalled, the wake flag is high in any cycle where request AND enable is nonzero, whatever the master enable. At the next edge the stall ends and the mode returns to 0.
- R8: Dispatch is strobed only when the master enable is set and request AND enable is nonzero. A wake with the master enable clear leaves the request bits untouched.
- R9: The dispatched source is the lowest-numbered pending bit (bit 0 highest priority). Its vector is 0x40 + 8 × bit index, and the clear mask is one-hot at that bit.
- R10: At the edge that ends a dispatch cycle, the master enable and the serviced request bit are cleared, and every other request bit is kept.
- R11: A halt pulse is ignored while the mode is not 0, and also in a cycle that strobes dispatch.
- R12: The cycle-cost output reads 4 in a cycle with a halt pulse or a stall, and 0 otherwise.
- R13: A master-enable set pulse sets it at the next edge and a clear pulse clears it. When both arrive together, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_op_i | input | 1 | One-cycle pulse: halt opcode executed |
| ime_set_i | input | 1 | Pulse that sets the master enable |
| ime_clr_i | input | 1 | Pulse that clears the master enable |
| irq_set_i | input | 5 | Peripheral request set pulses |
| bus_addr_i | input | 16 | Bus address |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 8 | Bus write data |
| bus_rdata_o | output | 8 | Bus read data for the addressed register |
| bus_hit_o | output | 1 | Address selects one of the two registers |
| ime_o | output | 1 | Master enable state |
| halt_mode_o | output | 2 | 0 run, 1 halted with enable set, 2 halted none pending, 3 halt-bug |
| halted_o | output | 1 | Core stall request |
| halt_bug_o | output | 1 | Skip the next PC increment |
| resume_o | output | 1 | Wake condition seen while stalled |
| halt_cyc_o | output | 3 | Cycle cost of the current step |
| dispatch_o | output | 1 | Interrupt dispatch strobe |
| vector_o | output | 8 | Vector of the dispatched source |
| clr_mask_o | output | 5 | One-hot bit being serviced |

## Verification
The assertions assume that the core does not treat a halt pulse as meaningful while a stall or halt-bug cycle is already in progress. They also assume that peripheral set pulses last one cycle each. The bench drives every input once per cycle at the falling edge. It raises the halt pulse only from the run state, except in the one test that checks the pulse is ignored. It loads the registers only while the master enable is clear, so no dispatch fires half-way through setting up a case.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NSRC = 5,
  parameter int STEP_CYC = 4,
  parameter int VEC_SHIFT = 3,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 16'hFF0F,
  parameter logic [ADDR_W-1:0] ENA_ADDR = 16'hFFFF,
  parameter logic [DATA_W-1:0] VEC_BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_op_i,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  input  logic [NSRC-1:0]   irq_set_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_hit_o,
  output logic              ime_o,
  output logic [1:0]        halt_mode_o,
  output logic              halted_o,
  output logic              halt_bug_o,
  output logic              resume_o,
  output logic [$clog2(STEP_CYC+1)-1:0] halt_cyc_o,
  output logic              dispatch_o,
  output logic [DATA_W-1:0] vector_o,
  output logic [NSRC-1:0]   clr_mask_o
);
  localparam int SEL_W = $clog2(NSRC);
  localparam int CYC_W = $clog2(STEP_CYC+1);
  localparam logic [1:0] M_RUN = 2'd0, M_IME = 2'd1, M_NONE = 2'd2, M_BUG = 2'd3;

  logic [NSRC-1:0]   req_q;
  logic [DATA_W-1:0] ena_q;
  logic              ime_q;
  logic [1:0]        mode_q;
  logic [NSRC-1:0]   pend;
  logic              any_pend;
  logic [SEL_W-1:0]  sel;
  logic              req_sel, ena_sel;

  assign req_sel  = bus_addr_i == REQ_ADDR;
  assign ena_sel  = bus_addr_i == ENA_ADDR;
  assign pend     = req_q & ena_q[NSRC-1:0];
  assign any_pend = |pend;

  always_comb begin
    sel = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (pend[i]) sel = SEL_W'(i);
  end

  assign dispatch_o  = ime_q & any_pend;
  assign vector_o    = VEC_BASE + (DATA_W'(sel) << VEC_SHIFT);
  assign clr_mask_o  = dispatch_o ? (NSRC'(1) << sel) : '0;
  assign halted_o    = (mode_q == M_IME) || (mode_q == M_NONE);
  assign halt_bug_o  = mode_q == M_BUG;
  assign resume_o    = halted_o & any_pend;
  assign halt_mode_o = mode_q;
  assign ime_o       = ime_q;
  assign halt_cyc_o  = (halt_op_i | halted_o) ? CYC_W'(STEP_CYC) : '0;
  assign bus_hit_o   = req_sel | ena_sel;
  assign bus_rdata_o = req_sel ? {{(DATA_W-NSRC){1'b1}}, req_q} :
                       ena_sel ? ena_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      ena_q  <= '0;
      ime_q  <= 1'b0;
      mode_q <= M_RUN;
    end else begin
      req_q <= (((bus_wr_i && req_sel) ? bus_wdata_i[NSRC-1:0] : req_q) & ~clr_mask_o)
               | irq_set_i;
      if (bus_wr_i && ena_sel) ena_q <= bus_wdata_i;

      if (dispatch_o || ime_clr_i) ime_q <= 1'b0;
      else if (ime_set_i)          ime_q <= 1'b1;

      if (mode_q == M_RUN) begin
        if (halt_op_i && !dispatch_o)
          mode_q <= ime_q ? M_IME : (any_pend ? M_BUG : M_NONE);
      end else if (mode_q == M_BUG) begin
        mode_q <= M_RUN;
      end else if (any_pend) begin
        mode_q <= M_RUN;
      end
    end
  end
endmodule

module halt_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_op_i,
  input logic       ime_o,
  input logic [1:0] halt_mode_o,
  input logic       halted_o,
  input logic       halt_bug_o,
  input logic       resume_o,
  input logic       dispatch_o,
  input logic [4:0] clr_mask_o,
  input logic [4:0] req_q,
  input logic [7:0] ena_q
);
  a_r6_bug_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    halt_bug_o |=> !halt_bug_o);
  a_r6_bug_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    halt_bug_o |-> !halted_o);
  a_r8_dispatch_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_o |-> ime_o);
  a_r9_mask_single: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_o |-> ($countones(clr_mask_o) == 1 && (clr_mask_o & req_q & ena_q[4:0]) != 5'd0));
  a_r10_ime_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch_o |=> !ime_o);
  a_r7_wake_leaves_stall: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> (!halted_o && halt_mode_o == 2'd0));
  a_r4_halt_ime_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_op_i && ime_o && !dispatch_o && halt_mode_o == 2'd0) |=> (halted_o && halt_mode_o == 2'd1));
  a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !resume_o) |=> $stable(halt_mode_o));
endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .halt_op_i(halt_op_i), .ime_o(ime_o),
  .halt_mode_o(halt_mode_o), .halted_o(halted_o), .halt_bug_o(halt_bug_o),
  .resume_o(resume_o), .dispatch_o(dispatch_o), .clr_mask_o(clr_mask_o),
  .req_q(req_q), .ena_q(ena_q)
);

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_op = 0, ime_set = 0, ime_clr = 0, bus_wr = 0;
  logic [4:0] irq_set = '0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, vector;
  logic bus_hit, ime, halted, halt_bug, resume, dispatch;
  logic [1:0] mode;
  logic [2:0] halt_cyc;
  logic [4:0] clr_mask;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  halt_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .halt_op_i(halt_op), .ime_set_i(ime_set), .ime_clr_i(ime_clr),
    .irq_set_i(irq_set), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .bus_hit_o(bus_hit), .ime_o(ime), .halt_mode_o(mode),
    .halted_o(halted), .halt_bug_o(halt_bug), .resume_o(resume), .halt_cyc_o(halt_cyc),
    .dispatch_o(dispatch), .vector_o(vector), .clr_mask_o(clr_mask));

  // {dispatch, request, enable, vector, mask}
  localparam logic [23:0] TBL [10] = '{
    {1'b1, 5'h1f, 5'h1f, 8'h40, 5'h01},
    {1'b1, 5'h1e, 5'h1f, 8'h48, 5'h02},
    {1'b1, 5'h1c, 5'h1f, 8'h50, 5'h04},
    {1'b1, 5'h18, 5'h1f, 8'h58, 5'h08},
    {1'b1, 5'h10, 5'h1f, 8'h60, 5'h10},
    {1'b1, 5'h1f, 5'h1e, 8'h48, 5'h02},
    {1'b0, 5'h15, 5'h0a, 8'h00, 5'h00},
    {1'b1, 5'h0c, 5'h18, 8'h58, 5'h08},
    {1'b1, 5'h06, 5'h1c, 8'h50, 5'h04},
    {1'b1, 5'h11, 5'h10, 8'h60, 5'h10}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse_ime(input bit s, input bit c);
    @(negedge clk); ime_set = s; ime_clr = c;
    @(negedge clk); ime_set = 0; ime_clr = 0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ime", ime, 0);
    chk("R1 mode", mode, 0);
    chk("R1 dispatch", dispatch, 0);
    rd(16'hFF0F, d); chk("R1 req reg", d, 8'hE0);
    rd(16'hFFFF, d); chk("R1 ena reg", d, 8'h00);

    // R2 register access
    wr(16'hFFFF, 8'hFF); rd(16'hFFFF, d); chk("R2 ena readback", d, 8'hFF);
    wr(16'hFF0F, 8'hFF); rd(16'hFF0F, d); chk("R2 req readback", d, 8'hFF);
    wr(16'hFF0F, 8'h00); rd(16'hFF0F, d); chk("R2 req cleared", d, 8'hE0);
    rd(16'hFF10, d); chk("R2 other addr", d, 8'h00); chk("R2 hit low", bus_hit, 0);

    // R3 write and set pulse together
    @(negedge clk); bus_addr = 16'hFF0F; bus_wdata = 8'h01; bus_wr = 1; irq_set = 5'h04;
    @(negedge clk); bus_wr = 0; irq_set = 0;
    rd(16'hFF0F, d); chk("R3 or merge", d, 8'hE5);
    @(negedge clk); bus_wdata = 8'h00; bus_wr = 1; irq_set = 5'h02;
    @(negedge clk); bus_wr = 0; irq_set = 0;
    rd(16'hFF0F, d); chk("R3 pulse wins", d, 8'hE2);
    wr(16'hFF0F, 8'h00);

    // R13 enable set/clear
    pulse_ime(1, 0); chk("R13 set", ime, 1);
    pulse_ime(1, 1); chk("R13 clear wins", ime, 0);

    // table walk: R8 R9 R10
    foreach (TBL[i]) begin
      logic [23:0] e;
      e = TBL[i];
      pulse_ime(0, 1);
      wr(16'hFFFF, {3'b000, e[17:13]});
      wr(16'hFF0F, {3'b000, e[22:18]});
      pulse_ime(1, 0);
      chk("R8 dispatch", dispatch, e[23]);
      if (e[23]) begin
        chk("R9 vector", vector, e[12:5]);
        chk("R9 mask", clr_mask, e[4:0]);
      end
      @(negedge clk);
      chk("R10 ime", ime, !e[23]);
      rd(16'hFF0F, d); chk("R10 req after", d, {3'b111, e[22:18] & ~e[4:0]});
    end

    // R5 halt with no pending, enable clear
    pulse_ime(0, 1);
    wr(16'hFFFF, 8'h1F);
    wr(16'hFF0F, 8'h00);
    @(negedge clk); halt_op = 1; #1 chk("R12 cost on halt", halt_cyc, 4);
    @(negedge clk); halt_op = 0;
    chk("R5 mode", mode, 2); chk("R5 stall", halted, 1);
    chk("R12 cost stalled", halt_cyc, 4);
    @(negedge clk); halt_op = 1;
    @(negedge clk); halt_op = 0; chk("R11 ignored while halted", mode, 2);
    // R7 wake with enable clear
    @(negedge clk); irq_set = 5'h08;
    @(negedge clk); irq_set = 0;
    chk("R7 resume", resume, 1); chk("R8 no dispatch", dispatch, 0);
    @(negedge clk);
    chk("R7 stall released", halted, 0); chk("R7 mode run", mode, 0);
    chk("R12 cost idle", halt_cyc, 0);
    rd(16'hFF0F, d); chk("R8 request kept", d, 8'hE8);

    // R6 halt bug
    @(negedge clk); halt_op = 1;
    @(negedge clk); halt_op = 0;
    chk("R6 mode", mode, 3); chk("R6 flag", halt_bug, 1); chk("R6 no stall", halted, 0);
    @(negedge clk);
    chk("R6 one shot", halt_bug, 0); chk("R6 back to run", mode, 0);

    // R4 halt with enable set, then wake and dispatch
    wr(16'hFF0F, 8'h00);
    pulse_ime(1, 0);
    @(negedge clk); halt_op = 1;
    @(negedge clk); halt_op = 0;
    chk("R4 mode", mode, 1); chk("R4 stall", halted, 1);
    @(negedge clk); irq_set = 5'h02;
    @(negedge clk); irq_set = 0;
    chk("R7 resume ime", resume, 1); chk("R8 dispatch", dispatch, 1);
    chk("R9 vector lcd", vector, 8'h48);
    @(negedge clk);
    chk("R7 released", halted, 0); chk("R10 ime off", ime, 0);
    rd(16'hFF0F, d); chk("R10 bit cleared", d, 8'hE0);

    // R11 halt in a dispatch cycle
    wr(16'hFF0F, 8'h10);
    pulse_ime(1, 0);
    chk("R11 dispatch up", dispatch, 1);
    halt_op = 1;
    @(negedge clk); halt_op = 0;
    chk("R11 no halt on dispatch", mode, 0); chk("R10 ime off 2", ime, 0);

    done = 1;
    report();
  end
endmodule